// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block keeps the control and status word of a scalar floating-point unit. Software writes the word and reads it back over a simple single-cycle register port. A three-bit rounding field is decoded into a two-bit mode that steers the arithmetic units. The block reports an unsupported rounding selection on a one-cycle error pulse.

The arithmetic units raise five exception conditions as one-cycle pulses. These pulses accumulate in sticky flags that stay set until software reloads them. The value read back is the masked stored image with the live sticky flags OR-ed into the low bits. A separate one-bit port lets the compare logic update the condition bit.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset the read value is 0, the rounding mode output is 0 (nearest-even) and the error output is low.
- R2: A write keeps only bits 29 and 12:5 of the written word. Every other stored bit reads as 0.
- R3: Rounding field bits 12:10 encode 0 = nearest-even, 1 = toward zero, 2 = toward +infinity and 3 = toward -infinity. When a write changes the field to one of these values, the mode output takes that value from the next cycle.
- R4: When a write changes the rounding field to 4, 5, 6 or 7, the error output is high for exactly the next cycle. The mode output keeps its previous value.
- R5: The field is decoded only when a write changes it. Rewriting the stored rounding value raises no error and leaves the mode unchanged.
- R6: Flag pulse inputs set sticky flags at read bits 4:0: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact. The flags stay set across cycles with no write.
- R7: A write reloads the sticky flags from bits 9:5 of the written word.
- R8: A flag pulse in the same cycle as a write sets its flag regardless of the reloaded value.
- R9: The read value is combinational and equals the stored image OR-ed with the sticky flags in bits 4:0.
- R10: A condition update loads bit 29 from the condition input. It overrides bit 29 of a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write value |
| rd_data_o | output | 32 | Register read value |
| flag_set_i | input | 5 | Exception flag pulses from the datapath |
| cond_we_i | input | 1 | Condition bit update strobe |
| cond_i | input | 1 | Condition bit value |
| rnd_mode_o | output | 2 | Decoded rounding mode |
| rnd_abort_o | output | 1 | Unsupported rounding mode pulse |

## Verification
The bench rewrites an illegal rounding value that is already stored. A design that decodes on every write would pulse the error again, and one that latched a bad mode would drive it to the datapath. It writes ones into flag bit positions with the trap field clear. A design that stored the flag bits would read back flags that never reload to zero. It also collides a flag pulse with a clearing write and a condition update with a write to bit 29. A wrong priority in either case loses the datapath event.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_POS     = 2'd2,
    RND_NEG     = 2'd3
  } rnd_mode_e;

  localparam int unsigned FLAG_N   = 5;
  localparam int unsigned FLAG_LSB = 0;
  localparam int unsigned TRAP_LSB = 5;
  localparam int unsigned RND_LSB  = 10;
  localparam int unsigned RND_W    = 3;
  localparam int unsigned COND_BIT = 29;
endpackage

// File: rtl/fpcsr_sticky.sv
module fpcsr_sticky #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] load_val_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flags_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= 1'b0;
      else if (set_i[k]) q <= 1'b1;  // datapath wins over reload
      else if (load_i)  q <= load_val_i[k];
    end
    assign flags_o[k] = q;
  end
endmodule

// File: rtl/fpcsr_image.sv
module fpcsr_image #(
  parameter int unsigned DATA_W   = 32,
  parameter logic [31:0] WR_MASK  = 32'h2000_1FE0,
  parameter int unsigned COND_BIT = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cond_we_i,
  input  logic              cond_i,
  output logic [DATA_W-1:0] image_o
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(WR_MASK);

  logic [DATA_W-1:0] img_q, img_d;

  always_comb begin
    img_d = img_q;
    if (wr_i) img_d = wr_data_i;
    if (cond_we_i) img_d[COND_BIT] = cond_i;
    img_d = img_d & MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) img_q <= '0;
    else         img_q <= img_d;
  end

  assign image_o = img_q;
endmodule

// File: rtl/fpcsr_rnd_decode.sv
module fpcsr_rnd_decode
  import fpcsr_pkg::*;
#(
  parameter int unsigned FW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [FW-1:0] new_field_i,
  input  logic [FW-1:0] old_field_i,
  output rnd_mode_e     mode_o,
  output logic          abort_o
);
  logic      changed, legal, abort_q;
  rnd_mode_e mode_q;

  assign changed = wr_i && (new_field_i != old_field_i);
  assign legal   = (new_field_i[FW-1:2] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= RND_NEAREST;
      abort_q <= 1'b0;
    end else begin
      abort_q <= changed && !legal;
      if (changed && legal) mode_q <= rnd_mode_e'(new_field_i[1:0]);
    end
  end

  assign mode_o  = mode_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter logic [31:0] WR_MASK = 32'h2000_1FE0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [FLAG_N-1:0] flag_set_i,
  input  logic              cond_we_i,
  input  logic              cond_i,
  output logic [1:0]        rnd_mode_o,
  output logic              rnd_abort_o
);
  logic [DATA_W-1:0] image;
  logic [FLAG_N-1:0] flags;
  rnd_mode_e         mode;

  fpcsr_image #(
    .DATA_W(DATA_W), .WR_MASK(WR_MASK), .COND_BIT(COND_BIT)
  ) i_image (
    .clk_i, .rst_ni,
    .wr_i      (wr_en_i),
    .wr_data_i (wr_data_i),
    .cond_we_i (cond_we_i),
    .cond_i    (cond_i),
    .image_o   (image)
  );

  fpcsr_sticky #(.N(FLAG_N)) i_sticky (
    .clk_i, .rst_ni,
    .load_i     (wr_en_i),
    .load_val_i (wr_data_i[TRAP_LSB +: FLAG_N]),
    .set_i      (flag_set_i),
    .flags_o    (flags)
  );

  fpcsr_rnd_decode #(.FW(RND_W)) i_rnd (
    .clk_i, .rst_ni,
    .wr_i        (wr_en_i),
    .new_field_i (wr_data_i[RND_LSB +: RND_W]),
    .old_field_i (image[RND_LSB +: RND_W]),
    .mode_o      (mode),
    .abort_o     (rnd_abort_o)
  );

  always_comb begin
    rd_data_o = image;
    rd_data_o[FLAG_LSB +: FLAG_N] = image[FLAG_LSB +: FLAG_N] | flags;
  end

  assign rnd_mode_o = mode;
endmodule

// File: rtl/fpcsr_unit_chk.sv
module fpcsr_unit_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter logic [31:0] WR_MASK = 32'h2000_1FE0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [4:0]        flag_set_i,
  input logic              cond_we_i,
  input logic              cond_i,
  input logic [1:0]        rnd_mode_o,
  input logic              rnd_abort_o
);
  localparam logic [DATA_W-1:0] VIS = DATA_W'(WR_MASK) | DATA_W'(32'h1F);

  a_r2_masked_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~VIS) == '0);

  a_r6_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> rd_data_o[4:0] == $past(rd_data_o[4:0] | flag_set_i));

  a_r7_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[4:0] == $past(wr_data_i[9:5] | flag_set_i));

  a_r4_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_abort_o |-> $stable(rnd_mode_o));

  a_r5_no_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !rnd_abort_o);

  a_r3_mode_stable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rnd_mode_o));

  a_r10_cond_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_we_i |=> rd_data_o[29] == $past(cond_i));
endmodule

bind fpcsr_unit fpcsr_unit_chk #(.DATA_W(DATA_W), .WR_MASK(WR_MASK)) i_chk (.*);

// File: tb/test_fpcsr_unit.sv
module test_fpcsr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [4:0]  flag_set_i = '0;
  logic        cond_we_i = 1'b0;
  logic        cond_i = 1'b0;
  logic [1:0]  rnd_mode_o;
  logic        rnd_abort_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  fpcsr_unit i_fpcsr_unit (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic pulse(logic [4:0] f);
    @(negedge clk_i); flag_set_i = f;
    @(negedge clk_i); flag_set_i = '0;
  endtask

  task automatic t_reset;
    check("R1 rd", rd_data_o, 32'h0);
    check("R1 mode", 32'(rnd_mode_o), 32'h0);
    check("R1 abort", 32'(rnd_abort_o), 32'h0);
  endtask

  task automatic t_mask;
    wr(32'hFFFF_E3FF);
    check("R2 R9 masked read", rd_data_o, 32'h2000_03FF);
    check("R3 mode unchanged", 32'(rnd_mode_o), 32'h0);
    wr(32'h0000_001F);
    check("R2 flag bits not stored", rd_data_o, 32'h0);
  endtask

  task automatic t_modes;
    for (int m = 1; m < 5; m++) begin
      wr(32'(m % 4) << 10);
      check("R3 mode", 32'(rnd_mode_o), 32'(m % 4));
      check("R3 no abort", 32'(rnd_abort_o), 32'h0);
    end
  endtask

  task automatic t_illegal;
    wr(32'h1 << 10);
    wr(32'h4 << 10);
    check("R4 abort on 4", 32'(rnd_abort_o), 32'h1);
    check("R4 mode held", 32'(rnd_mode_o), 32'h1);
    check("R4 field stored", rd_data_o, 32'h4 << 10);
    @(negedge clk_i);
    check("R4 one-cycle pulse", 32'(rnd_abort_o), 32'h0);
    wr(32'h4 << 10);
    check("R5 same field no abort", 32'(rnd_abort_o), 32'h0);
    check("R5 mode held", 32'(rnd_mode_o), 32'h1);
    wr(32'h5 << 10);
    check("R4 abort on 5", 32'(rnd_abort_o), 32'h1);
    wr(32'h6 << 10);
    check("R4 abort on 6", 32'(rnd_abort_o), 32'h1);
    wr(32'h2 << 10);
    check("R3 legal after illegal", 32'(rnd_mode_o), 32'h2);
    check("R3 no abort", 32'(rnd_abort_o), 32'h0);
    wr(32'h2 << 10);
    check("R5 rewrite legal", 32'(rnd_mode_o), 32'h2);
    wr(32'h0);
  endtask

  task automatic t_sticky;
    pulse(5'b00100);
    check("R6 flag set", rd_data_o, 32'h4);
    repeat (3) @(negedge clk_i);
    check("R6 flag holds", rd_data_o, 32'h4);
    pulse(5'b00001);
    check("R6 flags accumulate", rd_data_o, 32'h5);
  endtask

  task automatic t_reload;
    wr(32'h0000_02C0);
    check("R7 reload from trap field", rd_data_o, 32'h0000_02D6);
    wr(32'h0);
    check("R7 reload clears", rd_data_o, 32'h0);
  endtask

  task automatic t_collide;
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = '0; flag_set_i = 5'b01000;
    @(negedge clk_i); wr_en_i = 1'b0; flag_set_i = '0;
    check("R8 pulse beats write", rd_data_o, 32'h8);
    wr(32'h0);
  endtask

  task automatic t_cond;
    @(negedge clk_i); cond_we_i = 1'b1; cond_i = 1'b1;
    @(negedge clk_i); cond_we_i = 1'b0;
    check("R10 cond set", rd_data_o, 32'h2000_0000);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = 32'h2000_0000;
    cond_we_i = 1'b1; cond_i = 1'b0;
    @(negedge clk_i); wr_en_i = 1'b0; cond_we_i = 1'b0;
    check("R10 cond beats write", rd_data_o, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_mask;
    t_modes;
    t_illegal;
    t_sticky;
    t_reload;
    t_collide;
    t_cond;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule